// File: doc/BRIEF.md
# Single-Port SDRAM Controller with Power-Up Sequencer

This block connects a simple valid/ready host port to one external SDRAM device. The device is 32 bits wide, with 4 internal banks, 12 row bits and 8 column bits. The host issues single-word reads and writes. For each one the controller opens the row, performs the column access and closes all banks again. No row is left open between requests, so every access takes the same number of cycles no matter what came before it.

After reset the controller holds clock enable low. It then raises clock enable and waits a programmable number of cycles. Next it runs a fixed script: one precharge of all banks, eight auto-refresh commands, and a load of the mode register with burst length 1 and CAS latency 3. Only then does it accept host requests. From that point on, a down-counter reloaded from `cfg_refresh_count` raises a refresh request whenever it expires. The controller serves that request ahead of any new host access, and only after every row is closed.

Every change of command is gated by a down-counter loaded with the gap that the next command needs. The gaps are derived from tRCD, tRAS, tWR, tRP, tRC and tMRD at elaboration time. Read data is sampled three clocks after the READ command and is returned with a one-cycle strobe.

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is held, `sd_cke` is 0, the command pins {cs_n,ras_n,cas_n,we_n} show NOP (0111), and both `host_ready` and `init_done` are 0.
- R2: After reset, `sd_cke` goes to 1 and stays high for at least INIT_WAIT cycles before the first non-NOP command. That first command is PRECHARGE (0010) with A10=1.
- R3: The precharge is followed by exactly 8 AUTO REFRESH commands (0001) and then one LOAD MODE (0000). The LOAD MODE carries bank 0 and the address 0x230: A[2:0]=000 (burst length 1), A3=0 (sequential), A[6:4]=011 (latency 3), A[8:7]=00 and A9=1 (single-word write burst). `init_done` rises in the same cycle as the LOAD MODE.
- R4: `host_ready` is 0 whenever `init_done` is 0. A request is taken in a cycle where `host_valid` and `host_ready` are both 1.
- R5: Each accepted request produces three commands in this order. First ACTIVE (0011), with bank = host_addr[21:20] and row = host_addr[19:8]. Then READ (0101) or WRITE (0100), with A[7:0] = host_addr[7:0] and A10=0. Then PRECHARGE with A10=1. The pins show NOP in every other cycle.
- R6: Command spacing in clocks meets these minimums: ACTIVE to READ/WRITE 2; ACTIVE to PRECHARGE 4; WRITE to PRECHARGE 2; PRECHARGE to the next ACTIVE or AUTO REFRESH 2; ACTIVE or AUTO REFRESH to the next ACTIVE or AUTO REFRESH 7; LOAD MODE to ACTIVE 2.
- R7: In a WRITE cycle, `sd_dq_oe` is 1, `sd_dq_out` holds the host's write data and `sd_dqm` is 0000. `sd_dq_oe` is 0 in every other cycle.
- R8: For a READ on the pins in cycle t, `rd_valid` is high for exactly one cycle, t+4. In that cycle `rd_data` holds the value the device drove for the third edge after the READ. Reads return in issue order.
- R9: With no host traffic, successive AUTO REFRESH commands are exactly `cfg_refresh_count`+1 cycles apart. A new count takes effect at the next reload.
- R10: AUTO REFRESH is issued only when no row is open. A pending refresh holds `host_ready` low. Under back-to-back host traffic, refreshes keep pace with the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_refresh_count | input | 16 | Reload value of the refresh down-counter |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Controller takes the request this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Word address {bank, row, column} |
| host_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 32 | Captured read data |
| init_done | output | 1 | Power-up script finished |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Row/column/mode address |
| sd_dq_out | output | 32 | Data driven to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Data returned by the device |
| sd_dqm | output | 4 | Byte masks, 0 = byte enabled |

## Verification
A refresh-counter expiry and a host request can arrive together. They can also overlap with an access whose row is still open. The bench provokes this by shortening the refresh count and streaming random back-to-back requests, so expiries land at every phase of the access. It judges the outcome at the pins. No AUTO REFRESH may appear while its own row-open tracking says a row is open, and every spacing rule must hold around the refresh. The refresh count over the window must match the counter period. Every read must still return the shadow-memory value, in order.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_OFF, ST_PALL, ST_IREF, ST_LMR, ST_IDLE, ST_RW, ST_PRE
  } sd_state_e;

  // Cycles from READ/WRITE to PRECHARGE: honour tRAS (measured from ACTIVE) and tWR.
  function automatic int unsigned rw_to_pre(int unsigned t_ras, int unsigned t_rcd,
                                            int unsigned t_wr, bit is_wr);
    int unsigned ras_part;
    int unsigned wr_part;
    ras_part = (t_ras > t_rcd) ? t_ras - t_rcd : 1;
    wr_part  = is_wr ? t_wr : 1;
    return (ras_part > wr_part) ? ras_part : wr_part;
  endfunction

  // Cycles from PRECHARGE to the next row command: tRP and what remains of tRC.
  function automatic int unsigned pre_to_next(int unsigned t_rp, int unsigned t_rc,
                                              int unsigned t_rcd, int unsigned rw_gap);
    int unsigned used;
    int unsigned rest;
    used = t_rcd + rw_gap;
    rest = (t_rc > used) ? t_rc - used : 0;
    return (t_rp > rest) ? t_rp : rest;
  endfunction

  // Mode register word: burst 1, sequential, given latency, standard mode, single write.
  function automatic logic [15:0] mode_image(int unsigned cas_lat);
    logic [15:0] m;
    m      = '0;
    m[6:4] = cas_lat[2:0];
    m[9]   = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REF_W-1:0] reload,
  input  logic             ack,
  output logic             pend
);
  logic [REF_W-1:0] cnt_q;
  logic             expire;

  assign expire = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      if (!run)        cnt_q <= reload;
      else if (expire) cnt_q <= reload;
      else             cnt_q <= cnt_q - 1'b1;
      if (expire)      pend <= 1'b1;
      else if (ack)    pend <= 1'b0;
    end
  end

  a_r9_no_pend_before_run: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pend);
endmodule

// File: rtl/sdc_rd_capture.sv
module sdc_rd_capture #(
  parameter int DATA_W  = 32,
  parameter int CAS_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [CAS_LAT-1:0] pipe_q;

  generate
    if (CAS_LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= rd_issue;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[CAS_LAT-2:0], rd_issue};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pipe_q[CAS_LAT-1];
      if (pipe_q[CAS_LAT-1]) rd_data <= dq_in;
    end
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_issue, CAS_LAT + 1));
endmodule

// File: rtl/sdc_fsm.sv
module sdc_fsm
  import sdc_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 32,
  parameter int INIT_WAIT = 10000,
  parameter int INIT_REFS = 8,
  parameter int CAS_LAT   = 3,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 2,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_valid,
  input  logic                          host_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0] host_addr,
  input  logic [DATA_W-1:0]             host_wdata,
  output logic                          host_ready,
  input  logic                          ref_pend,
  output logic                          ref_ack,
  output logic                          init_done,
  output logic                          cke,
  output sd_cmd_e                       cmd,
  output logic [BANK_W-1:0]             ba,
  output logic [ROW_W-1:0]              a,
  output logic [DATA_W-1:0]             dq_out,
  output logic                          dq_oe,
  output logic [DATA_W/8-1:0]           dqm
);
  localparam int          AP_BIT  = 10;
  localparam int          WAIT_W  = $clog2(INIT_WAIT + T_RC + 2);
  localparam int          RCNT_W  = $clog2(INIT_REFS + 1);
  localparam int          SAT_W   = $clog2(T_RC + 2);
  localparam int unsigned GAP_RD  = rw_to_pre(T_RAS, T_RCD, T_WR, 1'b0);
  localparam int unsigned GAP_WR  = rw_to_pre(T_RAS, T_RCD, T_WR, 1'b1);
  localparam int unsigned CLS_RD  = pre_to_next(T_RP, T_RC, T_RCD, GAP_RD);
  localparam int unsigned CLS_WR  = pre_to_next(T_RP, T_RC, T_RCD, GAP_WR);
  localparam logic [15:0] MODE_W  = mode_image(CAS_LAT);

  sd_state_e           st_q;
  logic [WAIT_W-1:0]   dly_q;
  logic [RCNT_W-1:0]   refs_left_q;
  logic                we_q;
  logic [COL_W-1:0]    col_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                accept;

  assign host_ready = init_done && (st_q == ST_IDLE) && (dly_q == '0) && !ref_pend;
  assign accept     = host_valid && host_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_OFF;
      dly_q       <= '0;
      refs_left_q <= '0;
      we_q        <= 1'b0;
      col_q       <= '0;
      wdata_q     <= '0;
      init_done   <= 1'b0;
      cke         <= 1'b0;
      cmd         <= CMD_NOP;
      ba          <= '0;
      a           <= '0;
      dq_out      <= '0;
      dq_oe       <= 1'b0;
      dqm         <= '1;
      ref_ack     <= 1'b0;
    end else begin
      cmd     <= CMD_NOP;
      dq_oe   <= 1'b0;
      ref_ack <= 1'b0;
      if (dly_q != '0) begin
        dly_q <= dly_q - 1'b1;
      end else begin
        case (st_q)
          ST_OFF: begin
            cke   <= 1'b1;
            dly_q <= WAIT_W'(INIT_WAIT - 1);
            st_q  <= ST_PALL;
          end
          ST_PALL: begin
            cmd         <= CMD_PRE;
            a           <= '0;
            a[AP_BIT]   <= 1'b1;
            dly_q       <= WAIT_W'(T_RP - 1);
            refs_left_q <= RCNT_W'(INIT_REFS);
            st_q        <= ST_IREF;
          end
          ST_IREF: begin
            cmd         <= CMD_REF;
            dly_q       <= WAIT_W'(T_RC - 1);
            refs_left_q <= refs_left_q - 1'b1;
            if (refs_left_q == RCNT_W'(1)) st_q <= ST_LMR;
          end
          ST_LMR: begin
            cmd       <= CMD_LMR;
            ba        <= '0;
            a         <= MODE_W[ROW_W-1:0];
            dly_q     <= WAIT_W'(T_MRD - 1);
            init_done <= 1'b1;
            st_q      <= ST_IDLE;
          end
          ST_IDLE: begin
            if (init_done && ref_pend) begin
              cmd     <= CMD_REF;
              ref_ack <= 1'b1;
              dly_q   <= WAIT_W'(T_RC - 1);
            end else if (accept) begin
              cmd     <= CMD_ACT;
              ba      <= host_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
              a       <= host_addr[ROW_W+COL_W-1 -: ROW_W];
              we_q    <= host_write;
              col_q   <= host_addr[COL_W-1:0];
              wdata_q <= host_wdata;
              dly_q   <= WAIT_W'(T_RCD - 1);
              st_q    <= ST_RW;
            end
          end
          ST_RW: begin
            cmd            <= we_q ? CMD_WR : CMD_RD;
            a              <= '0;
            a[COL_W-1:0]   <= col_q;
            dqm            <= '0;
            dq_out         <= wdata_q;
            dq_oe          <= we_q;
            dly_q          <= WAIT_W'((we_q ? GAP_WR : GAP_RD) - 1);
            st_q           <= ST_PRE;
          end
          ST_PRE: begin
            cmd       <= CMD_PRE;
            a         <= '0;
            a[AP_BIT] <= 1'b1;
            dly_q     <= WAIT_W'((we_q ? CLS_WR : CLS_RD) - 1);
            st_q      <= ST_IDLE;
          end
          default: st_q <= ST_OFF;
        endcase
      end
    end
  end

  // Observation counters for the assertions (saturating, cycles since last event).
  logic [SAT_W-1:0] since_act_q, since_row_q, since_pre_q;
  logic             row_open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act_q <= SAT_W'(T_RC);
      since_row_q <= SAT_W'(T_RC);
      since_pre_q <= SAT_W'(T_RC);
      row_open_q  <= 1'b0;
    end else begin
      since_act_q <= (cmd == CMD_ACT) ? SAT_W'(1) :
                     (since_act_q < SAT_W'(T_RC)) ? since_act_q + 1'b1 : since_act_q;
      since_row_q <= (cmd == CMD_ACT || cmd == CMD_REF) ? SAT_W'(1) :
                     (since_row_q < SAT_W'(T_RC)) ? since_row_q + 1'b1 : since_row_q;
      since_pre_q <= (cmd == CMD_PRE) ? SAT_W'(1) :
                     (since_pre_q < SAT_W'(T_RC)) ? since_pre_q + 1'b1 : since_pre_q;
      if (cmd == CMD_ACT)      row_open_q <= 1'b1;
      else if (cmd == CMD_PRE) row_open_q <= 1'b0;
    end
  end

  a_r4_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !host_ready);
  a_r6_rcd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> since_act_q >= SAT_W'(T_RCD));
  a_r6_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE && row_open_q) |-> since_act_q >= SAT_W'(T_RAS));
  a_r6_rc: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT || cmd == CMD_REF) |-> since_row_q >= SAT_W'(T_RC));
  a_r6_rp: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT || cmd == CMD_REF) |-> since_pre_q >= SAT_W'(T_RP));
  a_r10_ref_rows_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> !row_open_q);
  a_r7_oe_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (cmd == CMD_WR));
  a_r2_cke_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == CMD_NOP));
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdc_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 32,
  parameter int REF_W     = 16,
  parameter int INIT_WAIT = 10000,
  parameter int INIT_REFS = 8,
  parameter int CAS_LAT   = 3,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 2,
  parameter int T_RC      = 7,
  parameter int T_MRD     = 2,
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W,
  localparam int MASK_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REF_W-1:0]  cfg_refresh_count,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              init_done,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in,
  output logic [MASK_W-1:0] sd_dqm
);
  sd_cmd_e cmd;
  logic    ref_pend, ref_ack;

  sdc_refresh_timer #(.REF_W(REF_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done), .reload(cfg_refresh_count),
    .ack(ref_ack), .pend(ref_pend)
  );

  sdc_fsm #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .INIT_WAIT(INIT_WAIT), .INIT_REFS(INIT_REFS), .CAS_LAT(CAS_LAT),
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_WR(T_WR), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .ref_pend(ref_pend), .ref_ack(ref_ack), .init_done(init_done), .cke(sd_cke),
    .cmd(cmd), .ba(sd_ba), .a(sd_a), .dq_out(sd_dq_out), .dq_oe(sd_dq_oe), .dqm(sd_dqm)
  );

  sdc_rd_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .rd_issue(cmd == CMD_RD), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  a_r10_ref_blocks_host: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !host_ready);
endmodule

// File: tb/test_sdram_ctrl.sv
module test_sdram_ctrl;
  localparam int INIT_WAIT = 200;
  localparam int T_RCD = 2, T_RAS = 4, T_WR = 2, T_RP = 2, T_RC = 7, T_MRD = 2, CL = 3;

  logic        clk = 0, rst_n = 0;
  logic [15:0] cfg_refresh_count;
  logic        host_valid = 0, host_write = 0;
  logic        host_ready;
  logic [21:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        rd_valid, init_done;
  logic [31:0] rd_data;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  logic [31:0] sd_dq_out, sd_dq_in;
  logic [3:0]  sd_dqm;

  sdram_ctrl #(.INIT_WAIT(INIT_WAIT)) i_sdram_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_refresh_count(cfg_refresh_count),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .init_done(init_done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in), .sd_dqm(sd_dqm)
  );

  always #10 clk = ~clk;

  int nvec = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] enc_nop();  return 4'b0111; endfunction
  function automatic logic [3:0] enc_act();  return 4'b0011; endfunction
  function automatic logic [3:0] enc_rd();   return 4'b0101; endfunction
  function automatic logic [3:0] enc_wr();   return 4'b0100; endfunction
  function automatic logic [3:0] enc_pre();  return 4'b0010; endfunction
  function automatic logic [3:0] enc_ref();  return 4'b0001; endfunction
  function automatic logic [3:0] enc_lmr();  return 4'b0000; endfunction
  function automatic logic [11:0] exp_mode(); return 12'h200 | 12'(CL << 4); endfunction

  // ---------------- SDRAM behavioural model ----------------
  logic [31:0] mem [logic [21:0]];
  logic [11:0] open_row [4];
  logic [31:0] mp1 = 32'hBAD0BAD0, mp2 = 32'hBAD0BAD0;
  logic [3:0]  pins;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  initial sd_dq_in = 32'hBAD0BAD0;

  always @(posedge clk) begin
    logic [21:0] key;
    key = {sd_ba, open_row[sd_ba], sd_a[7:0]};
    if (pins == enc_act()) open_row[sd_ba] = sd_a;
    if (pins == enc_wr()) mem[key] = sd_dq_out;
    mp1 <= (pins == enc_rd()) ? (mem.exists(key) ? mem[key] : 32'h0) : 32'hBAD0BAD0;
    mp2 <= mp1;
    sd_dq_in <= mp2;
  end

  // ---------------- shadow and monitor ----------------
  logic [31:0] shadow [logic [21:0]];
  logic [31:0] exp_q[$];
  int          rdcyc_q[$];
  logic [21:0] acc_addr;
  logic [31:0] acc_data;
  bit          acc_we;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int t_cke = -1, t_act = -1000, t_rw = -1000, t_wr = -1000, t_pre = -1000, t_row = -1000;
  int t_lmr = -1000;
  int init_refs = 0, ref_total = 0, ref_t0 = 0, ref_t1 = 0;
  bit first_cmd_seen = 0, row_open = 0, last_wr = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sd_cke && t_cke < 0) t_cke = cyc;
      if (!init_done) chk(!host_ready, "R4 ready before init", {31'b0, host_ready}, 0);
      if (sd_dq_oe && pins != enc_wr()) chk(0, "R7 oe outside write", {28'b0, pins}, enc_wr());
      if (pins != enc_nop() && !first_cmd_seen) begin
        first_cmd_seen = 1;
        chk(pins == enc_pre() && sd_a[10], "R2 first command", {20'b0, pins, sd_a[10], 7'b0}, {20'b0, enc_pre(), 8'h80});
        chk(cyc - t_cke >= INIT_WAIT, "R2 power wait", cyc - t_cke, INIT_WAIT);
      end
      case (pins)
        enc_act(): begin
          chk(cyc - t_row >= T_RC, "R6 row cycle", cyc - t_row, T_RC);
          chk(cyc - t_pre >= T_RP, "R6 precharge period", cyc - t_pre, T_RP);
          chk(cyc - t_lmr >= T_MRD, "R6 mode to active", cyc - t_lmr, T_MRD);
          chk({sd_ba, sd_a} == acc_addr[21:8], "R5 bank/row", {18'b0, sd_ba, sd_a}, {18'b0, acc_addr[21:8]});
          t_act = cyc; t_row = cyc; row_open = 1;
        end
        enc_rd(), enc_wr(): begin
          chk(cyc - t_act >= T_RCD, "R6 act to column", cyc - t_act, T_RCD);
          chk(sd_a[7:0] == acc_addr[7:0] && !sd_a[10], "R5 column", {20'b0, sd_a}, {24'b0, acc_addr[7:0]});
          chk((pins == enc_wr()) == acc_we, "R5 direction", {28'b0, pins}, acc_we ? enc_wr() : enc_rd());
          last_wr = (pins == enc_wr());
          if (last_wr) begin
            t_wr = cyc;
            chk(sd_dq_oe && sd_dqm == 4'b0, "R7 write enables", {27'b0, sd_dq_oe, sd_dqm}, 32'h10);
            chk(sd_dq_out == acc_data, "R7 write data", sd_dq_out, acc_data);
          end else rdcyc_q.push_back(cyc);
          t_rw = cyc;
        end
        enc_pre(): begin
          chk(sd_a[10], "R5 precharge all", {31'b0, sd_a[10]}, 1);
          if (row_open) begin
            chk(cyc - t_act >= T_RAS, "R6 active to precharge", cyc - t_act, T_RAS);
            if (last_wr) chk(cyc - t_wr >= T_WR, "R6 write recovery", cyc - t_wr, T_WR);
          end
          t_pre = cyc; row_open = 0;
        end
        enc_ref(): begin
          chk(!row_open, "R10 refresh with row open", {31'b0, row_open}, 0);
          chk(cyc - t_row >= T_RC, "R6 refresh row cycle", cyc - t_row, T_RC);
          chk(cyc - t_pre >= T_RP, "R6 refresh after precharge", cyc - t_pre, T_RP);
          if (!init_done) init_refs++;
          else begin ref_total++; ref_t1 = ref_t0; ref_t0 = cyc; end
          t_row = cyc;
        end
        enc_lmr(): begin
          chk(init_refs == 8, "R3 init refresh count", init_refs, 8);
          chk(sd_a == exp_mode() && sd_ba == 0, "R3 mode image", {18'b0, sd_ba, sd_a}, {20'b0, exp_mode()});
          chk(init_done, "R3 init_done with mode load", {31'b0, init_done}, 1);
          t_lmr = cyc;
        end
        default: ;
      endcase
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected rd_valid", rd_data, 0);
        else begin
          logic [31:0] e;
          int rc;
          e = exp_q.pop_front();
          rc = rdcyc_q.pop_front();
          chk(rd_data == e, "R8 read data", rd_data, e);
          chk(cyc - rc == CL + 1, "R8 read latency", cyc - rc, CL + 1);
        end
      end
    end
  end

  task automatic do_op(bit wr, logic [21:0] addr, logic [31:0] data);
    @(negedge clk);
    host_valid = 1; host_write = wr; host_addr = addr; host_wdata = data;
    forever begin
      #1;
      if (host_ready) break;
      @(negedge clk);
    end
    acc_addr = addr; acc_we = wr; acc_data = data;
    if (wr) shadow[addr] = data;
    else exp_q.push_back(shadow.exists(addr) ? shadow[addr] : 32'h0);
    @(posedge clk);
    #1 host_valid = 0;
  endtask

  function automatic logic [21:0] rnd_addr();
    return {2'($urandom), 12'($urandom % 4) * 12'h155, 8'($urandom % 8) * 8'h21};
  endfunction

  task automatic idle_gap(int rc);
    int n0;
    cfg_refresh_count = 16'(rc);
    n0 = ref_total;
    while (ref_total < n0 + 3) @(negedge clk);
    chk(ref_t0 - ref_t1 == rc + 1, "R9 idle refresh period", ref_t0 - ref_t1, rc + 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    int s0, r0, dur;
    void'($urandom(32'd4242));
    cfg_refresh_count = 16'd99;
    repeat (4) @(negedge clk);
    chk(!sd_cke && pins == enc_nop() && !host_ready && !init_done, "R1 reset state",
        {26'b0, sd_cke, pins, host_ready}, {27'b0, enc_nop(), 1'b0});
    rst_n = 1;
    while (!init_done) @(negedge clk);
    // R5 R7 R8 directed corners: highest and lowest address fields
    do_op(1, 22'h3FFFFF, 32'hA5A5_0F0F);
    do_op(1, 22'h000000, 32'h1234_5678);
    do_op(0, 22'h3FFFFF, 0);
    do_op(0, 22'h000000, 0);
    do_op(0, 22'h155021, 0);
    for (int i = 0; i < 60; i++) do_op(1'($urandom), rnd_addr(), $urandom);
    idle_gap(99);
    idle_gap(50);
    // R10 stress: short refresh period under back-to-back traffic
    cfg_refresh_count = 16'd20;
    s0 = cyc; r0 = ref_total;
    for (int i = 0; i < 150; i++) do_op(1'($urandom), rnd_addr(), $urandom);
    dur = cyc - s0;
    chk(ref_total - r0 >= dur / 21 - 1, "R10 refresh keeps pace", ref_total - r0, dur / 21 - 1);
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
    summary();
  end
endmodule